// File: doc/BRIEF.md
# Serial Four-Bit Adder with Step Controller

This block adds two 4-bit unsigned operands one bit position per clock cycle, least significant position first. One full adder serves every position. Each operand passes through a multiplexer that is indexed by the current step and picks the bit for that step. A single carry flip-flop links each step to the next. Each result bit enters a sum register at its most significant end, and the older contents move one place toward bit 0. After the fourth step the register holds the complete sum in natural bit order.

A small controller sequences the datapath. It waits in an idle state until `start` is seen. It then captures both operands and the carry-in and clears the sum register. It runs four add steps and raises `done` for one cycle before it returns to idle. On the first step the controller tells the adder to take the external carry. On the later steps it takes the carry stored from the step before. The result stays on `sum` and `carry_out` until the next operation begins.

Top module: `serial_adder`

## Requirements
- R1: While `rst` is high on a clock edge, the design clears `sum`, `carry_out` and `done` to zero and returns the controller to idle.
- R2: A `start` sampled in idle begins an operation. `done` goes high exactly four clock edges after the capturing edge.
- R3: The capturing edge clears `sum` to 0000. Each step handles one bit position, from bit 0 to bit 3, and shifts its result bit into `sum[3]` while moving the older bits right. For A=0110, B=1100 and carry-in 0, `sum` reads 0000, 1000, 0100 and 0010 after the four steps.
- R4: Step 0 uses the captured external carry-in and every later step uses the stored carry. When `done` is high, {`carry_out`,`sum`} equals A + B + carry-in for all operand values, with carry-in 0 or 1.
- R5: The design ignores a `start` that arrives while an operation runs. The result is that of the operands captured first.
- R6: Changes on `a_in`, `b_in` or `carry_in` after the capturing edge do not affect the result.
- R7: In idle with `start` low, `sum` and `carry_out` hold their values.
- R8: `done` stays high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an addition when idle |
| a_in | input | 4 | Operand A |
| b_in | input | 4 | Operand B |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 4 | Sum register |
| carry_out | output | 1 | Stored carry; final carry when `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step index or carry-source select corrupts a specific bit position. The fault shows as a wrong `sum` value at the `done` cycle, and the worked example's intermediate register values expose it one cycle after the faulty step. A stuck or miscounting controller shows at once as a `done` that arrives early, late or for more than one cycle. A missing operand capture or a re-triggered start shows only at completion, as a result that belongs to the wrong operands.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    localparam int unsigned OPW  = 4;
    localparam int unsigned IDXW = (OPW > 1) ? $clog2(OPW) : 1;
    localparam int unsigned RESW = OPW + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADD  = 2'd1,
        ST_DONE = 2'd2
    } sa_state_e;

    typedef struct packed {
        logic [IDXW-1:0] sel;      // bit position for this step
        logic            cin_sel;  // 0: external carry, 1: stored carry
        logic            shift;    // shift the sum register
        logic            ce;       // enable carry and sum registers
        logic            clr;      // capture operands, clear sum
    } sa_ctrl_t;

    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sa_bitmux.sv
module sa_bitmux #(
    parameter int unsigned W  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [W-1:0]  word_i,
    input  logic [IW-1:0] sel_i,
    output logic          bit_o
);
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_dec
        assign hit[i] = word_i[i] & (sel_i == IW'(i));
    end

    assign bit_o = |hit;
endmodule

// File: rtl/sa_full_adder.sv
module sa_full_adder
    import serial_add_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    assign s_o = fa_sum(a_i, b_i, c_i);
    assign c_o = fa_carry(a_i, b_i, c_i);
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import serial_add_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output sa_ctrl_t ctrl_o,
    output logic     done_o,
    output logic     busy_o
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(OPW - 1);

    sa_state_e       st_q;
    logic [IDXW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (start_i) st_q <= ST_ADD;
                end
                ST_ADD: begin
                    if (idx_q == LAST_IDX) begin
                        st_q  <= ST_DONE;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + IDXW'(1);
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctrl_o         = '0;
        ctrl_o.sel     = idx_q;
        ctrl_o.cin_sel = (idx_q != '0);
        ctrl_o.shift   = (st_q == ST_ADD);
        ctrl_o.ce      = (st_q == ST_ADD);
        ctrl_o.clr     = (st_q == ST_IDLE) && start_i;
    end

    assign done_o = (st_q == ST_DONE);
    assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/sa_datapath.sv
module sa_datapath
    import serial_add_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  sa_ctrl_t       ctrl_i,
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic           cin_i,
    output logic [OPW-1:0] sum_o,
    output logic           carry_o,
    output logic [OPW-1:0] a_q,
    output logic [OPW-1:0] b_q,
    output logic           cin_q
);
    logic abit, bbit, cbit, sbit, cnext;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
        end else if (ctrl_i.clr) begin
            a_q   <= a_i;
            b_q   <= b_i;
            cin_q <= cin_i;
        end
    end

    sa_bitmux #(.W(OPW), .IW(IDXW)) u_amux (.word_i(a_q), .sel_i(ctrl_i.sel), .bit_o(abit));
    sa_bitmux #(.W(OPW), .IW(IDXW)) u_bmux (.word_i(b_q), .sel_i(ctrl_i.sel), .bit_o(bbit));

    assign cbit = ctrl_i.cin_sel ? carry_o : cin_q;

    sa_full_adder u_fa (.a_i(abit), .b_i(bbit), .c_i(cbit), .s_o(sbit), .c_o(cnext));

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_o <= 1'b0;
            sum_o   <= '0;
        end else if (ctrl_i.clr) begin
            carry_o <= 1'b0;
            sum_o   <= '0;
        end else if (ctrl_i.ce) begin
            carry_o <= cnext;
            if (ctrl_i.shift) sum_o <= {sbit, sum_o[OPW-1:1]};
        end
    end
endmodule

// File: rtl/serial_adder.sv
module serial_adder
    import serial_add_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [OPW-1:0] a_in,
    input  logic [OPW-1:0] b_in,
    input  logic           carry_in,
    output logic [OPW-1:0] sum,
    output logic           carry_out,
    output logic           done
);
    sa_ctrl_t       ctrl;
    logic           busy;
    logic [OPW-1:0] a_q, b_q;
    logic           cin_q;

    sa_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start_i(start),
        .ctrl_o(ctrl), .done_o(done), .busy_o(busy)
    );

    sa_datapath u_dp (
        .clk(clk), .rst(rst), .ctrl_i(ctrl),
        .a_i(a_in), .b_i(b_in), .cin_i(carry_in),
        .sum_o(sum), .carry_o(carry_out),
        .a_q(a_q), .b_q(b_q), .cin_q(cin_q)
    );
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk
    import serial_add_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           done,
    input logic           busy,
    input logic [OPW-1:0] sum,
    input logic           carry_out,
    input logic [OPW-1:0] a_q,
    input logic [OPW-1:0] b_q,
    input logic           cin_q
);
    logic [IDXW:0] steps;

    always_ff @(posedge clk) begin
        if (rst || !busy) steps <= '0;
        else if (!done)   steps <= steps + 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
        done |-> (steps == (IDXW+1)'(OPW))); // R2
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && sum == '0)); // R3
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy); // R5
    AST_RESULT: assert property (@(posedge clk) disable iff (rst)
        done |-> ({carry_out, sum} == ({1'b0, a_q} + {1'b0, b_q} + RESW'(cin_q)))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(sum) && $stable(carry_out))); // R7
endmodule

bind serial_adder serial_adder_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .busy(busy),
    .sum(sum), .carry_out(carry_out), .a_q(a_q), .b_q(b_q), .cin_q(cin_q)
);

// File: tb/serial_adder_bench.sv
`timescale 1ns/1ps
module serial_adder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] a_in = '0, b_in = '0;
    logic       carry_in = 1'b0;
    logic [3:0] sum;
    logic       carry_out, done;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    serial_adder u_serial_adder (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .carry_in(carry_in), .sum(sum), .carry_out(carry_out), .done(done)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Start at a negedge; returns after the capturing edge, at the next negedge.
    task automatic launch(input logic [3:0] a, input logic [3:0] b, input logic c);
        a_in = a; b_in = b; carry_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_op(input string req, input int exp);
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R2 early done", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R2 done timing", done, 1);
        check({carry_out, sum} == exp[4:0], req, {carry_out, sum}, exp);
        @(negedge clk);
        check(done == 1'b0, "R8 done width", done, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(sum == 4'd0 && carry_out == 1'b0 && done == 1'b0, "R1 reset state",
              {done, carry_out, sum}, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_worked_example();
        launch(4'b0110, 4'b1100, 1'b0);
        check(sum == 4'b0000, "R3 cleared at start", sum, 0);
        @(negedge clk); check(sum == 4'b0000, "R3 step0", sum, 4'b0000);
        @(negedge clk); check(sum == 4'b1000, "R3 step1", sum, 4'b1000);
        @(negedge clk); check(sum == 4'b0100, "R3 step2", sum, 4'b0100);
        @(negedge clk); check(sum == 4'b0010, "R3 step3", sum, 4'b0010);
        check(done && carry_out, "R4 example carry", {done, carry_out}, 3);
        @(negedge clk);
        check(!done, "R8 example done width", done, 0);
    endtask

    task automatic t_exhaustive();
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    launch(4'(a), 4'(b), 1'(c));
                    finish_op("R4 sum", a + b + c);
                end
    endtask

    task automatic t_start_busy();
        launch(4'd9, 4'd9, 1'b1);
        start = 1'b1; a_in = 4'd1; b_in = 4'd2; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(done && {carry_out, sum} == 5'd19, "R5 start while busy",
              {carry_out, sum}, 19);
        @(negedge clk);
    endtask

    task automatic t_operand_change();
        launch(4'd15, 4'd1, 1'b0);
        a_in = 4'd0; b_in = 4'd0; carry_in = 1'b1;
        finish_op("R6 operands changed", 16);
    endtask

    task automatic t_hold();
        launch(4'd5, 4'd7, 1'b1);
        finish_op("R7 setup", 13);
        for (int i = 0; i < 5; i++) begin
            a_in = 4'(i); b_in = 4'(3 * i); carry_in = 1'(i);
            @(negedge clk);
        end
        check({carry_out, sum} == 5'd13, "R7 hold in idle", {carry_out, sum}, 13);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_worked_example();
        t_exhaustive();
        t_start_busy();
        t_operand_change();
        t_hold();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule